// File: doc/BRIEF.md
# Write-Once Fuse Array Controller

This block fronts a one-time-programmable fuse array that is modelled as on-chip storage of 32-bit words. Software reaches it over a 32-bit register bus with a valid/ready request and a registered response. The fuse macro's control pins are exposed as individual registers: word address, bit index, redundancy select, chip enable, clock, data in, data strobe, program, test control, test mode, test repeat, test read, trim and write enable. A read-only data-out register returns the addressed fuse word when the read path is open.

Programming is a side effect of writing the write-enable register. One bit, chosen by the word address and bit-index registers, is set or cleared from the data-in register. A parallel written-flag map, one flag per fuse bit, rejects any second program of the same bit and raises a sticky error. After reset a sequencer sweeps the whole array: every word becomes all ones, every flag is cleared, and a serial number and its complement are placed in two fixed neighbouring words.

The sequencer has three states. `ST_INIT` sweeps the array and moves to `ST_IDLE` after the last word. `ST_IDLE` accepts bus requests and moves to `ST_APPLY` on an accepted program request. `ST_APPLY` performs the read-modify-write of one fuse bit and its flag and returns to `ST_IDLE` after one cycle.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset, `req_ready` stays low while the array is initialised and rises within WORDS+4 cycles. From then on every fuse word reads 0xFFFFFFFF, every register reads zero, and `wo_err` and `access_err` are low.
- R2: After reset, word SERIAL_WORD holds SERIAL and word SERIAL_WORD+1 holds the bitwise complement of SERIAL.
- R3: Every accepted request (`req_valid` and `req_ready` high at a rising edge) produces `rsp_valid` high for exactly the following cycle, with read data on `rsp_rdata`. No response occurs without such a request.
- R4: The register byte offsets are 0x00 chip enable, 0x04 strobe, 0x08 trim, 0x0C word address, 0x10 bit index, 0x14 data in, 0x18 redundancy select, 0x1C write enable, 0x20 data out, 0x24 program, 0x28 clock, 0x2C test control, 0x30 test mode, 0x34 test repeat and 0x38 test read. Each reads back what was last written, except that the word address keeps only its low log2(WORDS) bits and write enable keeps only bit 0.
- R5: Writes to data out (0x20) are ignored.
- R6: A data-out read returns the fuse word at the current word address only when bit 0 of chip enable, strobe and trim are all set. Otherwise it returns 0x000000FF.
- R7: A word write to write enable with bit 0 set, while redundancy select is zero, programs one bit. The target is bit (bit index mod 32) of the addressed word. The bit is set if data in is nonzero and cleared if it is zero. `req_ready` is low in the cycle after such a write. A write-enable write with bit 0 clear programs nothing.
- R8: While redundancy select is nonzero, a write-enable write programs nothing and leaves the bit's written flag untouched.
- R9: A program of a bit whose written flag is set leaves the word unchanged and sets `wo_err`. The flag is set by every successful program. `wo_err` stays high until reset.
- R10: A request at an unmapped offset (beyond 0x38), at an offset not a multiple of 4, or with `req_size` other than 2 (word) has no effect and reads zero. It raises `access_err` for the response cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register byte offset |
| req_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data |
| access_err | output | 1 | Illegal access pulse, with the response |
| wo_err | output | 1 | Sticky write-once violation |

## Verification
A stuck or wrong sequencer state shows at once on `req_ready`: it either never rises after the sweep or stays low for more than the single cycle that follows a program request. A corrupted fuse word or written flag is invisible until software reads data out at that address, or tries to program the same bit again. The bench therefore reads the word back immediately after every program and then repeats a program on the same bit. A wrong init value shows on the first data-out read after reset, and a wrong error decode shows on `access_err` in the response cycle.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [1:0] {
        ST_INIT  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_APPLY = 2'd2
    } seq_state_t;

    localparam logic [7:0] OFF_CHIPEN = 8'h00;
    localparam logic [7:0] OFF_STROBE = 8'h04;
    localparam logic [7:0] OFF_TRIM   = 8'h08;
    localparam logic [7:0] OFF_ADDR   = 8'h0C;
    localparam logic [7:0] OFF_BITSEL = 8'h10;
    localparam logic [7:0] OFF_DIN    = 8'h14;
    localparam logic [7:0] OFF_REDSEL = 8'h18;
    localparam logic [7:0] OFF_WREN   = 8'h1C;
    localparam logic [7:0] OFF_DOUT   = 8'h20;
    localparam logic [7:0] OFF_PROG   = 8'h24;
    localparam logic [7:0] OFF_CLK    = 8'h28;
    localparam logic [7:0] OFF_TCTL   = 8'h2C;
    localparam logic [7:0] OFF_TMODE  = 8'h30;
    localparam logic [7:0] OFF_TREP   = 8'h34;
    localparam logic [7:0] OFF_TREAD  = 8'h38;
    localparam logic [7:0] OFF_LAST   = OFF_TREAD;

    localparam logic [1:0] SIZE_WORD  = 2'd2;
    localparam logic [31:0] DOUT_SHUT = 32'h0000_00FF;

    function automatic logic off_mapped(input logic [7:0] off);
        return (off[1:0] == 2'b00) && (off <= OFF_LAST);
    endfunction

endpackage

// File: rtl/otp_store.sv
module otp_store #(
    parameter int WORDS = 4096,
    parameter int W     = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/otp_regbank.sv
module otp_regbank
    import otp_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_off,
    input  logic [31:0]   wr_data,
    input  logic [7:0]    rd_off,
    output logic [31:0]   rd_mux,
    output logic [AW-1:0] word_addr,
    output logic [4:0]    bit_idx,
    output logic          din_set,
    output logic          redsel_zero,
    output logic          dout_open
);

    logic [31:0]   chipen_q, strobe_q, trim_q, bitsel_q, din_q, redsel_q;
    logic [31:0]   prog_q, clk_q, tctl_q, tmode_q, trep_q, tread_q;
    logic [AW-1:0] addr_q;
    logic          wren_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chipen_q <= '0;
            strobe_q <= '0;
            trim_q   <= '0;
            bitsel_q <= '0;
            din_q    <= '0;
            redsel_q <= '0;
            prog_q   <= '0;
            clk_q    <= '0;
            tctl_q   <= '0;
            tmode_q  <= '0;
            trep_q   <= '0;
            tread_q  <= '0;
            addr_q   <= '0;
            wren_q   <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_off)
                OFF_CHIPEN: chipen_q <= wr_data;
                OFF_STROBE: strobe_q <= wr_data;
                OFF_TRIM:   trim_q   <= wr_data;
                OFF_ADDR:   addr_q   <= wr_data[AW-1:0];
                OFF_BITSEL: bitsel_q <= wr_data;
                OFF_DIN:    din_q    <= wr_data;
                OFF_REDSEL: redsel_q <= wr_data;
                OFF_WREN:   wren_q   <= wr_data[0];
                OFF_PROG:   prog_q   <= wr_data;
                OFF_CLK:    clk_q    <= wr_data;
                OFF_TCTL:   tctl_q   <= wr_data;
                OFF_TMODE:  tmode_q  <= wr_data;
                OFF_TREP:   trep_q   <= wr_data;
                OFF_TREAD:  tread_q  <= wr_data;
                default:    ;
            endcase
        end
    end

    always_comb begin
        unique case (rd_off)
            OFF_CHIPEN: rd_mux = chipen_q;
            OFF_STROBE: rd_mux = strobe_q;
            OFF_TRIM:   rd_mux = trim_q;
            OFF_ADDR:   rd_mux = {{(32-AW){1'b0}}, addr_q};
            OFF_BITSEL: rd_mux = bitsel_q;
            OFF_DIN:    rd_mux = din_q;
            OFF_REDSEL: rd_mux = redsel_q;
            OFF_WREN:   rd_mux = {31'd0, wren_q};
            OFF_PROG:   rd_mux = prog_q;
            OFF_CLK:    rd_mux = clk_q;
            OFF_TCTL:   rd_mux = tctl_q;
            OFF_TMODE:  rd_mux = tmode_q;
            OFF_TREP:   rd_mux = trep_q;
            OFF_TREAD:  rd_mux = tread_q;
            default:    rd_mux = '0;
        endcase
    end

    assign word_addr   = addr_q;
    assign bit_idx     = bitsel_q[4:0];
    assign din_set     = |din_q;
    assign redsel_zero = (redsel_q == '0);
    assign dout_open   = chipen_q[0] & strobe_q[0] & trim_q[0];

endmodule

// File: rtl/otp_seq.sv
module otp_seq
    import otp_pkg::*;
#(
    parameter int WORDS = 4096,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_req,
    input  logic          flag_hit,
    output logic          ready,
    output logic          init_we,
    output logic [AW-1:0] init_idx,
    output logic          apply_ok,
    output logic          wo_err
);

    localparam logic [AW-1:0] LAST_IDX = AW'(WORDS - 1);

    seq_state_t    state_q, state_d;
    logic [AW-1:0] idx_q;
    logic          err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INIT;
            idx_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_INIT) begin
                idx_q <= idx_q + 1'b1;
            end
            if ((state_q == ST_APPLY) && flag_hit) begin
                err_q <= 1'b1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT:  if (idx_q == LAST_IDX) state_d = ST_IDLE;
            ST_IDLE:  if (prog_req)          state_d = ST_APPLY;
            ST_APPLY: state_d = ST_IDLE;
            default:  state_d = ST_INIT;
        endcase
    end

    always_comb begin
        ready    = 1'b0;
        init_we  = 1'b0;
        apply_ok = 1'b0;
        unique case (state_q)
            ST_INIT:  init_we  = 1'b1;
            ST_IDLE:  ready    = 1'b1;
            ST_APPLY: apply_ok = !flag_hit;
            default:  ;
        endcase
    end

    assign init_idx = idx_q;
    assign wo_err   = err_q;

endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
    import otp_pkg::*;
#(
    parameter int          WORDS       = 4096,
    parameter logic [31:0] SERIAL      = 32'h5EED_0A17,
    parameter int          SERIAL_WORD = 252
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [7:0]  req_addr,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        access_err,
    output logic        wo_err
);

    localparam int AW = $clog2(WORDS);
    localparam logic [AW-1:0] SER_IDX  = AW'(SERIAL_WORD);
    localparam logic [AW-1:0] SERC_IDX = AW'(SERIAL_WORD + 1);

    logic          acc, legal, reg_wr, prog_req;
    logic [31:0]   rd_mux;
    logic [AW-1:0] word_addr, init_idx;
    logic [4:0]    bit_idx;
    logic          din_set, redsel_zero, dout_open;
    logic          init_we, apply_ok;
    logic [31:0]   fuse_rd, flag_rd, bit_mask, init_val, patched;
    logic          fuse_we, flag_we;
    logic [AW-1:0] st_waddr;
    logic [31:0]   fuse_wdata, flag_wdata;

    logic          rsp_q, err_q, dout_q, open_q;
    logic [31:0]   reg_rd_q;

    assign acc      = req_valid && req_ready;
    assign legal    = (req_size == SIZE_WORD) && off_mapped(req_addr);
    assign reg_wr   = acc && req_write && legal;
    assign prog_req = reg_wr && (req_addr == OFF_WREN) && req_wdata[0] && redsel_zero;

    otp_regbank #(.AW(AW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr),
        .wr_off      (req_addr),
        .wr_data     (req_wdata),
        .rd_off      (req_addr),
        .rd_mux      (rd_mux),
        .word_addr   (word_addr),
        .bit_idx     (bit_idx),
        .din_set     (din_set),
        .redsel_zero (redsel_zero),
        .dout_open   (dout_open)
    );

    otp_seq #(.WORDS(WORDS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_req (prog_req),
        .flag_hit (flag_rd[bit_idx]),
        .ready    (req_ready),
        .init_we  (init_we),
        .init_idx (init_idx),
        .apply_ok (apply_ok),
        .wo_err   (wo_err)
    );

    assign bit_mask = 32'd1 << bit_idx;
    assign patched  = din_set ? (fuse_rd | bit_mask) : (fuse_rd & ~bit_mask);

    always_comb begin
        if (init_idx == SER_IDX) begin
            init_val = SERIAL;
        end else if (init_idx == SERC_IDX) begin
            init_val = ~SERIAL;
        end else begin
            init_val = '1;
        end
    end

    assign fuse_we    = init_we | apply_ok;
    assign flag_we    = init_we | apply_ok;
    assign st_waddr   = init_we ? init_idx : word_addr;
    assign fuse_wdata = init_we ? init_val : patched;
    assign flag_wdata = init_we ? 32'd0 : (flag_rd | bit_mask);

    otp_store #(.WORDS(WORDS), .W(32)) u_fuse (
        .clk   (clk),
        .we    (fuse_we),
        .waddr (st_waddr),
        .wdata (fuse_wdata),
        .raddr (word_addr),
        .rdata (fuse_rd)
    );

    otp_store #(.WORDS(WORDS), .W(32)) u_flag (
        .clk   (clk),
        .we    (flag_we),
        .waddr (st_waddr),
        .wdata (flag_wdata),
        .raddr (word_addr),
        .rdata (flag_rd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q    <= 1'b0;
            err_q    <= 1'b0;
            dout_q   <= 1'b0;
            open_q   <= 1'b0;
            reg_rd_q <= '0;
        end else begin
            rsp_q    <= acc;
            err_q    <= acc && !legal;
            dout_q   <= acc && !req_write && legal && (req_addr == OFF_DOUT);
            open_q   <= dout_open;
            reg_rd_q <= (acc && !req_write && legal) ? rd_mux : '0;
        end
    end

    assign rsp_valid  = rsp_q;
    assign access_err = err_q;
    assign rsp_rdata  = dout_q ? (open_q ? fuse_rd : DOUT_SHUT) : reg_rd_q;

endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk
    import otp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       req_write,
    input logic [7:0] req_addr,
    input logic [1:0] req_size,
    input logic       req_wdata_b0,
    input logic       rsp_valid,
    input logic       access_err,
    input logic       wo_err,
    input logic       redsel_zero
);

    assert_rsp_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready));

    assert_accept_gives_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    assert_err_only_with_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        access_err |-> rsp_valid);

    assert_bad_size_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_size != SIZE_WORD)) |=> access_err);

    assert_wo_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wo_err |=> wo_err);

    assert_prog_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && (req_addr == OFF_WREN) &&
         (req_size == SIZE_WORD) && req_wdata_b0 && redsel_zero) |=> !req_ready);

endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_size     (req_size),
    .req_wdata_b0 (req_wdata[0]),
    .rsp_valid    (rsp_valid),
    .access_err   (access_err),
    .wo_err       (wo_err),
    .redsel_zero  (redsel_zero)
);

// File: tb/otp_fuse_ctrl_tb.sv
`timescale 1ns/1ps
module otp_fuse_ctrl_tb;
    import otp_pkg::*;

    localparam int          WORDS       = 4096;
    localparam logic [31:0] SERIAL      = 32'h5EED_0A17;
    localparam int          SERIAL_WORD = 252;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [1:0]  req_size = SIZE_WORD;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        access_err;
    logic        wo_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    otp_fuse_ctrl #(.WORDS(WORDS), .SERIAL(SERIAL), .SERIAL_WORD(SERIAL_WORD)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .access_err(access_err), .wo_err(wo_err)
    );

    // {write, offset, data, expected read}
    localparam int NV = 24;
    localparam logic [72:0] VEC [NV] = '{
        {1'b1, OFF_ADDR,   32'hFFFF_FFFF, 32'h0},
        {1'b0, OFF_ADDR,   32'h0,         32'h0000_0FFF},
        {1'b1, OFF_BITSEL, 32'h0000_003F, 32'h0},
        {1'b0, OFF_BITSEL, 32'h0,         32'h0000_003F},
        {1'b1, OFF_DIN,    32'hA5A5_0000, 32'h0},
        {1'b0, OFF_DIN,    32'h0,         32'hA5A5_0000},
        {1'b1, OFF_WREN,   32'hFFFF_FFFE, 32'h0},
        {1'b0, OFF_WREN,   32'h0,         32'h0},
        {1'b1, OFF_PROG,   32'h1234_5678, 32'h0},
        {1'b0, OFF_PROG,   32'h0,         32'h1234_5678},
        {1'b1, OFF_CLK,    32'h0000_0001, 32'h0},
        {1'b0, OFF_CLK,    32'h0,         32'h0000_0001},
        {1'b1, OFF_TCTL,   32'hC0DE_0001, 32'h0},
        {1'b0, OFF_TCTL,   32'h0,         32'hC0DE_0001},
        {1'b1, OFF_TMODE,  32'h0000_00AA, 32'h0},
        {1'b0, OFF_TMODE,  32'h0,         32'h0000_00AA},
        {1'b1, OFF_TREP,   32'h8000_0000, 32'h0},
        {1'b0, OFF_TREP,   32'h0,         32'h8000_0000},
        {1'b1, OFF_TREAD,  32'h0F0F_0F0F, 32'h0},
        {1'b0, OFF_TREAD,  32'h0,         32'h0F0F_0F0F},
        {1'b1, OFF_REDSEL, 32'h0000_0007, 32'h0},
        {1'b0, OFF_REDSEL, 32'h0,         32'h0000_0007},
        {1'b1, OFF_DOUT,   32'hDEAD_BEEF, 32'h0},   // R5: ignored
        {1'b0, OFF_DOUT,   32'h0,         32'h0000_00FF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus(input logic wr, input logic [7:0] off, input logic [31:0] d,
                       input logic [1:0] sz, output logic [31:0] rd, output logic er,
                       output logic rdy_after);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = off;
        req_wdata = d;
        req_size  = sz;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rd        = rsp_rdata;
        er        = access_err;
        rdy_after = req_ready;
        chk("R3 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    endtask

    task automatic wr_reg(input logic [7:0] off, input logic [31:0] d);
        logic [31:0] rd;
        logic er, ra;
        bus(1'b1, off, d, SIZE_WORD, rd, er, ra);
    endtask

    task automatic rd_reg(input logic [7:0] off, output logic [31:0] rd);
        logic er, ra;
        bus(1'b0, off, 32'h0, SIZE_WORD, rd, er, ra);
    endtask

    task automatic do_reset();
        int n;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        chk("R1 ready low during init", {31'd0, req_ready}, 32'd0);
        while (!req_ready && n < WORDS + 10) begin
            @(negedge clk);
            n++;
        end
        chk("R1 init length", {31'd0, (n <= WORDS + 4)}, 32'd1);
    endtask

    task automatic open_read();
        wr_reg(OFF_CHIPEN, 32'h1);
        wr_reg(OFF_STROBE, 32'h1);
        wr_reg(OFF_TRIM,   32'h1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<=150000", cycles);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] rd;
        logic er, ra;

        do_reset();
        chk("R1 wo_err after reset", {31'd0, wo_err}, 32'd0);
        chk("R1 access_err after reset", {31'd0, access_err}, 32'd0);
        rd_reg(OFF_CHIPEN, rd);
        chk("R1 reg reset value", rd, 32'h0);

        // register table walk (R4, R5, R6 with read path shut)
        for (int i = 0; i < NV; i++) begin
            bus(VEC[i][72], VEC[i][71:64], VEC[i][63:32], SIZE_WORD, rd, er, ra);
            if (!VEC[i][72]) chk("R4 table", rd, VEC[i][31:0]);
        end
        wr_reg(OFF_REDSEL, 32'h0);

        // R1, R2: initial contents
        open_read();
        wr_reg(OFF_ADDR, 32'h0);
        rd_reg(OFF_DOUT, rd);
        chk("R1 word 0 all ones", rd, 32'hFFFF_FFFF);
        wr_reg(OFF_ADDR, SERIAL_WORD);
        rd_reg(OFF_DOUT, rd);
        chk("R2 serial", rd, SERIAL);
        wr_reg(OFF_ADDR, SERIAL_WORD + 1);
        rd_reg(OFF_DOUT, rd);
        chk("R2 serial complement", rd, ~SERIAL);

        // R6: each enable shuts the read path
        wr_reg(OFF_STROBE, 32'h2);
        rd_reg(OFF_DOUT, rd);
        chk("R6 strobe off", rd, 32'h0000_00FF);
        wr_reg(OFF_STROBE, 32'h1);
        wr_reg(OFF_TRIM, 32'h0);
        rd_reg(OFF_DOUT, rd);
        chk("R6 trim off", rd, 32'h0000_00FF);
        wr_reg(OFF_TRIM, 32'h1);

        // R7: clear bit 3 of word 5
        wr_reg(OFF_ADDR, 32'h5);
        wr_reg(OFF_BITSEL, 32'h3);
        wr_reg(OFF_DIN, 32'h0);
        bus(1'b1, OFF_WREN, 32'h1, SIZE_WORD, rd, er, ra);
        chk("R7 ready low after program", {31'd0, ra}, 32'd0);
        rd_reg(OFF_DOUT, rd);
        chk("R7 bit 3 cleared", rd, 32'hFFFF_FFF7);
        chk("R9 no error on first program", {31'd0, wo_err}, 32'd0);

        // R9: second program of bit 3 is rejected
        wr_reg(OFF_DIN, 32'h1);
        wr_reg(OFF_WREN, 32'h1);
        rd_reg(OFF_DOUT, rd);
        chk("R9 word unchanged", rd, 32'hFFFF_FFF7);
        chk("R9 wo_err set", {31'd0, wo_err}, 32'd1);

        // R7: bit 31 and bit index taken mod 32
        wr_reg(OFF_DIN, 32'h0);
        wr_reg(OFF_BITSEL, 32'd31);
        wr_reg(OFF_WREN, 32'h1);
        rd_reg(OFF_DOUT, rd);
        chk("R7 bit 31 cleared", rd, 32'h7FFF_FFF7);
        wr_reg(OFF_BITSEL, 32'd36);
        wr_reg(OFF_WREN, 32'h1);
        rd_reg(OFF_DOUT, rd);
        chk("R7 index mod 32", rd, 32'h7FFF_FFE7);
        wr_reg(OFF_BITSEL, 32'd1);
        wr_reg(OFF_WREN, 32'h0);
        rd_reg(OFF_DOUT, rd);
        chk("R7 enable bit clear", rd, 32'h7FFF_FFE7);

        // R8: redundancy select blocks programming and leaves the flag alone
        wr_reg(OFF_REDSEL, 32'h1);
        wr_reg(OFF_BITSEL, 32'd0);
        bus(1'b1, OFF_WREN, 32'h1, SIZE_WORD, rd, er, ra);
        chk("R8 no stall", {31'd0, ra}, 32'd1);
        rd_reg(OFF_DOUT, rd);
        chk("R8 word unchanged", rd, 32'h7FFF_FFE7);
        wr_reg(OFF_REDSEL, 32'h0);
        wr_reg(OFF_WREN, 32'h1);
        rd_reg(OFF_DOUT, rd);
        chk("R8 flag still clear", rd, 32'h7FFF_FFE6);

        // R10: illegal accesses
        bus(1'b0, 8'h3C, 32'h0, SIZE_WORD, rd, er, ra);
        chk("R10 unmapped reads zero", rd, 32'h0);
        chk("R10 unmapped err", {31'd0, er}, 32'd1);
        bus(1'b1, 8'h0D, 32'h9, SIZE_WORD, rd, er, ra);
        chk("R10 misaligned err", {31'd0, er}, 32'd1);
        bus(1'b1, OFF_ADDR, 32'h9, 2'd0, rd, er, ra);
        chk("R10 byte access err", {31'd0, er}, 32'd1);
        bus(1'b0, OFF_ADDR, 32'h0, SIZE_WORD, rd, er, ra);
        chk("R10 byte write ignored", rd, 32'h5);
        chk("R10 legal access no err", {31'd0, er}, 32'd0);
        @(negedge clk);
        chk("R10 err is one cycle", {31'd0, access_err}, 32'd0);
        chk("R9 wo_err still set", {31'd0, wo_err}, 32'd1);

        // reset again: array and flags restored
        do_reset();
        chk("R9 wo_err cleared by reset", {31'd0, wo_err}, 32'd0);
        open_read();
        wr_reg(OFF_ADDR, 32'h5);
        rd_reg(OFF_DOUT, rd);
        chk("R1 word restored", rd, 32'hFFFF_FFFF);
        wr_reg(OFF_BITSEL, 32'h3);
        wr_reg(OFF_WREN, 32'h1);
        rd_reg(OFF_DOUT, rd);
        chk("R1 flags cleared", rd, 32'hFFFF_FFF7);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule